// File: doc/BRIEF.md
# Timed Glitch Event Scheduler

The scheduler keeps an ordered list of glitch descriptors and plays them back against a slow-clock timer. Each descriptor has three fields: a start delay, a length in slow-clock periods and a pattern code. A downstream clock switcher uses the pattern code to choose how the fast clock is shaped. Descriptors are loaded through a plain write port while the block is idle.

A pulse on the trigger input resets the internal 32-bit timer and starts playback from the first stored descriptor. The first delay counts from the trigger. Every later delay counts from the end of the glitch before it, because the timer restarts each time a descriptor finishes. While a glitch is in service the block drives a strobe and the descriptor's pattern code. After the last descriptor the queue is emptied and a done flag rises. A new trigger during playback abandons the run and starts again from the head of the queue.

Top module: `glitch_sched`

## Requirements
- R1: After reset, glitch_o is low, pattern_o is 0, done_o is high and full_o is low.
- R2: A trigger restarts the timer. If the queue is not empty, the first strobe rises on the (t+1)-th rising edge after the edge that samples the trigger, where t is the first descriptor's timestamp.
- R3: The strobe stays high for exactly the descriptor's duration in clock cycles. While it is high, pattern_o carries the descriptor's pattern code; otherwise pattern_o is 0.
- R4: For every descriptor after the first, the strobe rises on the (t+1)-th rising edge after the edge on which the previous strobe fell.
- R5: Descriptors are played in the order they were written.
- R6: A descriptor with duration 0 produces no strobe. The next delay counts from the edge on which the skipped descriptor's timestamp was reached.
- R7: A write presented while a sequence is running is ignored.
- R8: full_o is high when DEPTH descriptors are stored. A write presented while full is ignored.
- R9: After the last descriptor has been served, the queue is empty and done_o is high on that same edge. A trigger on an empty queue produces no strobe, and done_o stays high.
- R10: A trigger during a running sequence aborts it. Playback restarts from the first descriptor, with the timer restarted at that trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start / restart pulse |
| wr_en_i | input | 1 | Descriptor write strobe |
| wr_time_i | input | 32 | Descriptor delay in cycles |
| wr_dur_i | input | 16 | Descriptor length in cycles |
| wr_pat_i | input | 2 | Descriptor pattern code |
| glitch_o | output | 1 | Glitch active strobe |
| pattern_o | output | 2 | Pattern code of active glitch, else 0 |
| done_o | output | 1 | Idle with empty queue |
| full_o | output | 1 | Queue holds DEPTH descriptors |

## Verification
All results appear one clock edge after the stimulus that causes them. Take the edge that samples the trigger, or the edge on which a strobe falls, as the reference. A strobe with delay t is first visible in the half-cycle after reference edge plus t+1, and it falls after the given duration. done_o is visible right after the edge that ends the last glitch. The bench drives inputs and samples outputs on falling edges, and it numbers cycles from the trigger's sampling edge. From the descriptor list it builds the complete expected strobe, pattern and done timeline, then compares every cycle of the run against it. Writes that should be rejected are injected at a known cycle in the middle of a run, and their absence is seen in that timeline.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_GLITCH = 2'd2
  } gs_state_e;
endpackage

// File: rtl/gs_timer.sv
module gs_timer #(
  parameter int TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  output logic [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign time_o = cnt_q;
endmodule

// File: rtl/gs_queue.sv
module gs_queue #(
  parameter int DEPTH = 256,
  parameter int DW    = 50,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             busy_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             full;
  logic             accept;

  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign accept = wr_en_i && !busy_i && !full;

  always_ff @(posedge clk_i) begin
    if (accept) mem_q[cnt_q[IDX_W-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (accept) cnt_q <= cnt_q + 1'b1;
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign count_o   = cnt_q;
  assign full_o    = full;
endmodule

// File: rtl/gs_engine.sv
module gs_engine
  import gs_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int DUR_W  = 16,
  parameter int PAT_W  = 2,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] ts_i,
  input  logic [DUR_W-1:0]  dur_i,
  input  logic [PAT_W-1:0]  pat_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              glitch_o,
  output logic [PAT_W-1:0]  pattern_o,
  output logic              busy_o,
  output logic              tmr_clr_o,
  output logic              q_clr_o
);
  gs_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [DUR_W-1:0] rem_q, rem_d;
  logic             adv;
  logic             last;

  assign last = (CNT_W'(idx_q) + 1'b1) == count_i;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    rem_d   = rem_q;
    adv     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_i && count_i != '0) begin
          state_d = ST_WAIT;
          idx_d   = '0;
        end
      end
      ST_WAIT: begin
        if (trig_i) begin
          idx_d = '0;
        end else if (time_i == ts_i) begin
          if (dur_i == '0) begin
            adv = 1'b1;  // zero-length: skip, restart delay here
          end else begin
            state_d = ST_GLITCH;
            rem_d   = dur_i;
          end
        end
      end
      ST_GLITCH: begin
        if (trig_i) begin
          state_d = ST_WAIT;
          idx_d   = '0;
        end else if (rem_q == DUR_W'(1)) begin
          adv = 1'b1;
        end else begin
          rem_d = rem_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (adv) begin
      if (last) begin
        state_d = ST_IDLE;
        idx_d   = '0;
      end else begin
        state_d = ST_WAIT;
        idx_d   = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rem_q   <= rem_d;
    end
  end

  assign glitch_o  = (state_q == ST_GLITCH);
  assign pattern_o = glitch_o ? pat_i : '0;
  assign busy_o    = (state_q != ST_IDLE);
  assign tmr_clr_o = trig_i || adv;
  assign q_clr_o   = adv && last;
  assign idx_o     = idx_q;
endmodule

// File: rtl/glitch_sched.sv
module glitch_sched #(
  parameter int TIME_W = 32,
  parameter int DUR_W  = 16,
  parameter int PAT_W  = 2,
  parameter int DEPTH  = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              wr_en_i,
  input  logic [TIME_W-1:0] wr_time_i,
  input  logic [DUR_W-1:0]  wr_dur_i,
  input  logic [PAT_W-1:0]  wr_pat_i,
  output logic              glitch_o,
  output logic [PAT_W-1:0]  pattern_o,
  output logic              done_o,
  output logic              full_o
);
  localparam int DW    = TIME_W + DUR_W + PAT_W;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TIME_W-1:0] cur_time;
  logic [DW-1:0]     rd_desc;
  logic [TIME_W-1:0] desc_ts;
  logic [DUR_W-1:0]  desc_dur;
  logic [PAT_W-1:0]  desc_pat;
  logic [CNT_W-1:0]  q_count;
  logic [IDX_W-1:0]  rd_idx;
  logic              busy;
  logic              tmr_clr;
  logic              q_clr;

  assign {desc_ts, desc_dur, desc_pat} = rd_desc;

  gs_timer #(.TIME_W(TIME_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .time_o (cur_time)
  );

  gs_queue #(.DEPTH(DEPTH), .DW(DW)) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i ({wr_time_i, wr_dur_i, wr_pat_i}),
    .busy_i    (busy),
    .clr_i     (q_clr),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_desc),
    .count_o   (q_count),
    .full_o    (full_o)
  );

  gs_engine #(
    .TIME_W(TIME_W), .DUR_W(DUR_W), .PAT_W(PAT_W), .DEPTH(DEPTH)
  ) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .time_i    (cur_time),
    .ts_i      (desc_ts),
    .dur_i     (desc_dur),
    .pat_i     (desc_pat),
    .count_i   (q_count),
    .idx_o     (rd_idx),
    .glitch_o  (glitch_o),
    .pattern_o (pattern_o),
    .busy_o    (busy),
    .tmr_clr_o (tmr_clr),
    .q_clr_o   (q_clr)
  );

  assign done_o = !busy && (q_count == '0);
endmodule

// File: rtl/gs_checker.sv
module gs_checker #(
  parameter int DUR_W = 16,
  parameter int PAT_W = 2,
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig_i,
  input logic             wr_en_i,
  input logic             glitch_i,
  input logic [PAT_W-1:0] pattern_i,
  input logic             done_i,
  input logic             busy_i,
  input logic             q_clr_i,
  input logic [CNT_W-1:0] count_i,
  input logic [IDX_W-1:0] idx_i,
  input logic [DUR_W-1:0] dur_i
);
  logic [DUR_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (glitch_i) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  assert_pattern_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glitch_i |-> pattern_i == '0);

  assert_glitch_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glitch_i |-> run_q < dur_i);

  assert_reject_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_en_i && !q_clr_i) |=> $stable(count_i));

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!glitch_i && !busy_i));

  assert_restart_head_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && count_i != '0 && !q_clr_i) |=> (busy_i && idx_i == '0));
endmodule

bind glitch_sched gs_checker #(
  .DUR_W(DUR_W), .PAT_W(PAT_W), .DEPTH(DEPTH)
) i_gs_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .trig_i    (trig_i),
  .wr_en_i   (wr_en_i),
  .glitch_i  (glitch_o),
  .pattern_i (pattern_o),
  .done_i    (done_o),
  .busy_i    (busy),
  .q_clr_i   (q_clr),
  .count_i   (q_count),
  .idx_i     (rd_idx),
  .dur_i     (desc_dur)
);

// File: tb/test_glitch_sched.sv
module test_glitch_sched;
  localparam int DEPTH = 256;
  localparam int TL    = 300;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trig_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_time_i = '0;
  logic [15:0] wr_dur_i = '0;
  logic [1:0]  wr_pat_i = '0;
  logic        glitch_o;
  logic [1:0]  pattern_o;
  logic        done_o;
  logic        full_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int n_desc;
  int ts_a [DEPTH+4];
  int dur_a[DEPTH+4];
  int pat_a[DEPTH+4];
  int eg[TL];
  int ep[TL];
  int done_c;

  always #5 clk_i = ~clk_i;

  glitch_sched #(.DEPTH(DEPTH)) i_glitch_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .wr_en_i(wr_en_i),
    .wr_time_i(wr_time_i), .wr_dur_i(wr_dur_i), .wr_pat_i(wr_pat_i),
    .glitch_o(glitch_o), .pattern_o(pattern_o), .done_o(done_o), .full_o(full_o)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic add_desc(int ts, int dur, int pat);
    ts_a[n_desc]  = ts;
    dur_a[n_desc] = dur;
    pat_a[n_desc] = pat;
    n_desc++;
  endtask

  task automatic wr(int ts, int dur, int pat);
    wr_en_i   = 1'b1;
    wr_time_i = 32'(ts);
    wr_dur_i  = 16'(dur);
    wr_pat_i  = 2'(pat);
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < n_desc; i++) wr(ts_a[i], dur_a[i], pat_a[i]);
  endtask

  task automatic pulse_trig();
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
  endtask

  // Expected timeline, cycle 0 = just after the trigger's sampling edge
  task automatic build_exp();
    int rf = 0;
    for (int c = 0; c < TL; c++) begin eg[c] = 0; ep[c] = 0; end
    for (int i = 0; i < n_desc; i++) begin
      if (dur_a[i] == 0) begin
        rf += ts_a[i] + 1;
      end else begin
        int rise = rf + ts_a[i] + 1;
        for (int k = 0; k < dur_a[i]; k++)
          if (rise + k < TL) begin eg[rise+k] = 1; ep[rise+k] = pat_a[i]; end
        rf = rise + dur_a[i];
      end
    end
    done_c = rf;
  endtask

  // Called right after the trigger pulse; compares every cycle
  task automatic run_trace(int len, int inj_c, string req);
    int bad = 0;
    int fc = -1;
    int fa = 0;
    int fe = 0;
    for (int c = 0; c < len; c++) begin
      int act, exp;
      if (c == inj_c) begin
        wr_en_i = 1'b1; wr_time_i = 32'd1; wr_dur_i = 16'd3; wr_pat_i = 2'd3;
      end
      if (c == inj_c + 1) wr_en_i = 1'b0;
      act = {29'd0, glitch_o, pattern_o};
      exp = (eg[c] << 2) | ep[c];
      if (c == done_c) begin act |= {done_o, 3'b000}; exp |= 8; end
      if (c == done_c - 1) act |= {done_o, 3'b000};
      if (act != exp) begin
        bad++;
        if (fc < 0) begin fc = c; fa = act; fe = exp; end
      end
      @(negedge clk_i);
    end
    wr_en_i = 1'b0;
    if (bad != 0) $display("  first mismatch at cycle %0d ({done,glitch,pattern})", fc);
    check(bad == 0, req, fa, fe);
  endtask

  task automatic t_reset();
    check(glitch_o == 1'b0, "R1 glitch", int'(glitch_o), 0);
    check(pattern_o == 2'd0, "R1 pattern", int'(pattern_o), 0);
    check(done_o == 1'b1, "R1 done", int'(done_o), 1);
    check(full_o == 1'b0, "R1 full", int'(full_o), 0);
  endtask

  task automatic t_single();  // R2, R3
    n_desc = 0;
    add_desc(3, 2, 1);
    load_all();
    check(done_o == 1'b0, "R9 not done with entries", int'(done_o), 0);
    build_exp();
    pulse_trig();
    run_trace(20, -1, "R2/R3 single glitch timeline");
  endtask

  task automatic t_chain();  // R4, R5
    n_desc = 0;
    add_desc(2, 3, 1);
    add_desc(4, 1, 2);
    add_desc(0, 2, 3);
    add_desc(1, 1, 1);
    load_all();
    build_exp();
    pulse_trig();
    run_trace(30, -1, "R4/R5 relative chain and order");
  endtask

  task automatic t_zero();  // R6
    n_desc = 0;
    add_desc(3, 0, 3);
    add_desc(2, 2, 2);
    load_all();
    build_exp();
    pulse_trig();
    run_trace(20, -1, "R6 zero duration skipped");
  endtask

  task automatic t_reject();  // R7
    n_desc = 0;
    add_desc(10, 2, 1);
    load_all();
    build_exp();
    pulse_trig();
    run_trace(25, 2, "R7 write while busy ignored");
    check(done_o == 1'b1, "R7 queue empty after run", int'(done_o), 1);
  endtask

  task automatic t_full();  // R8
    n_desc = 0;
    for (int i = 0; i < DEPTH - 1; i++) add_desc(0, 0, 0);
    add_desc(0, 1, 2);
    load_all();
    check(full_o == 1'b1, "R8 full at DEPTH", int'(full_o), 1);
    wr(0, 5, 3);
    check(full_o == 1'b1, "R8 still full after extra write", int'(full_o), 1);
    build_exp();
    pulse_trig();
    run_trace(270, -1, "R8 extra write ignored when full");
    check(full_o == 1'b0, "R8 full clears", int'(full_o), 0);
  endtask

  task automatic t_empty();  // R9
    n_desc = 0;
    build_exp();
    pulse_trig();
    run_trace(12, -1, "R9 trigger on empty queue");
  endtask

  task automatic t_abort();  // R10
    n_desc = 0;
    add_desc(5, 3, 1);
    add_desc(2, 2, 2);
    load_all();
    build_exp();
    pulse_trig();
    repeat (7) @(negedge clk_i);
    check(glitch_o == 1'b1, "R10 mid-glitch before abort", int'(glitch_o), 1);
    pulse_trig();
    run_trace(25, -1, "R10 retrigger restarts from head");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_single();
    t_chain();
    t_zero();
    t_reject();
    t_abort();
    t_empty();
    t_full();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule